// File: doc/BRIEF.md
# Extended-Format Target Address Generator

This block takes one fetched instruction of one to four bytes and works out its length, how its operand is addressed, and its effective address or immediate value. The caller supplies the instruction bytes left-aligned on a 32-bit bus (first byte in bits 31:24). It also supplies a two-bit class code that tells short register formats apart from memory-referencing ones, and the current base, index and program counter values. The program counter must already point past the instruction.

One clock after the inputs are presented, the block reports the decode. For a memory-referencing instruction, that decode includes a 20-bit target address, which wraps modulo 2^20. It also raises one of two flags: the address is really an immediate operand, or the caller must fetch a pointer word from that address before using it. The block does no memory access of its own. The caller performs every read, including the pointer dereference.

Top module: `xe_ta_gen`

## Requirements
- R1: Class code `cls_i` = 01 gives a 1-byte instruction and 10 gives a 2-byte one (len_o 1 or 2). opcode_o is the unmodified first byte. No memory is referenced: am_o=0, rel_o=0, idx_o=0, ext_o=0, ta_o=0, imm_vld_o=0, ind_req_o=0, err_o=0.
- R2: With `cls_i`=00 the instruction references memory, and opcode_o is the first byte with its two low bits cleared. The flags sit in instr_i[25:20] in the order n,i,x,b,p,e. If n or i is set: e=1 gives len_o=4 and ext_o=1, e=0 gives len_o=3 and ext_o=0, rel_o={b,p}, and idx_o=x. am_o is 1 when n=i=1, 2 for immediate (n=0,i=1) and 3 for indirect (n=1,i=0).
- R3: With b=p=0 (n or i set), the target address is the 12-bit displacement instr_i[19:8], zero-extended. With e=1 it is the 20-bit field instr_i[19:0].
- R4: With b=0 and p=1, the target address is the low 20 bits of pc_i plus the sign-extended 12-bit displacement. With e=1 it is pc_i plus the 20-bit field, unsigned. Either sum wraps modulo 2^20.
- R5: With b=1 and p=0, the target address is the low 20 bits of base_i plus the displacement, unsigned (or plus the 20-bit field when e=1), modulo 2^20.
- R6: x=1 adds the low 20 bits of idx_i to the computed address, modulo 2^20, in both simple and legacy addressing.
- R7: Immediate (n=0,i=1, no error) sets imm_vld_o=1. The value appears on ta_o.
- R8: Indirect (n=1,i=0, no error) sets ind_req_o=1.
- R9: With n=i=0 (legacy), the address is the 15-bit value {b,p,e,disp12} zero-extended, plus X when x=1. The outputs are len_o=3, am_o=4, rel_o=0, ext_o=0, idx_o=x, imm_vld_o=0 and ind_req_o=0.
- R10: Any of the following sets err_o=1 and forces ta_o=0, imm_vld_o=0 and ind_req_o=0: b=p=1 with n or i set, x=1 with immediate or indirect, or class 11. Class 11 also reports len_o=1, the raw opcode, and am_o=rel_o=idx_o=ext_o=0.
- R11: Every output is registered and reflects the inputs sampled at the previous rising clock edge. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction bytes, first byte in [31:24] |
| cls_i | input | 2 | 00 memory format, 01 one-byte, 10 two-byte, 11 reserved |
| base_i | input | 24 | Base register value |
| idx_i | input | 24 | Index register value |
| pc_i | input | 24 | Program counter, already past the instruction |
| len_o | output | 3 | Instruction length in bytes |
| opcode_o | output | 8 | Opcode (low two bits cleared for memory formats) |
| am_o | output | 3 | 0 none, 1 simple, 2 immediate, 3 indirect, 4 legacy |
| rel_o | output | 2 | Relative base: 00 none, 01 PC, 10 base, 11 illegal |
| idx_o | output | 1 | Indexing applied |
| ext_o | output | 1 | 4-byte extended form |
| ta_o | output | 20 | Target address or immediate value |
| imm_vld_o | output | 1 | ta_o holds an immediate operand |
| ind_req_o | output | 1 | Caller must dereference ta_o |
| err_o | output | 1 | Illegal flag combination |

## Verification
The cases hardest to reach from the ports are the wrap-around sums. These include a negative PC-relative displacement that takes a small PC below zero, and a base or index sum that crosses 2^20. Another is the pairing of extended format with PC-relative addressing. Directed vectors set pc_i, base_i and idx_i near zero or near the top of the space, with displacements of 0x800, 0xFFF and 0xFFFFF. A long random run, weighted toward the memory-referencing class, then covers the many flag combinations, and a behavioural model checks every field on every clock.

// File: rtl/xe_ta_gen.sv
module xe_ta_gen #(
  parameter int AW = 20,
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   instr_i,
  input  logic [1:0]    cls_i,
  input  logic [WW-1:0] base_i,
  input  logic [WW-1:0] idx_i,
  input  logic [WW-1:0] pc_i,
  output logic [2:0]    len_o,
  output logic [7:0]    opcode_o,
  output logic [2:0]    am_o,
  output logic [1:0]    rel_o,
  output logic          idx_o,
  output logic          ext_o,
  output logic [AW-1:0] ta_o,
  output logic          imm_vld_o,
  output logic          ind_req_o,
  output logic          err_o
);
  localparam logic [2:0] AM_NONE = 3'd0, AM_SIMPLE = 3'd1, AM_IMM = 3'd2,
                         AM_IND = 3'd3, AM_LEGACY = 3'd4;

  logic        fn, fi, fx, fb, fp, fe;
  logic [11:0] d12;
  logic [19:0] a20;
  assign {fn, fi, fx, fb, fp, fe} = instr_i[25:20];
  assign d12 = instr_i[19:8];
  assign a20 = instr_i[19:0];

  logic [AW-1:0] xoff, field, ta_n;
  logic [2:0]    len_n, am_n;
  logic [1:0]    rel_n;
  logic [7:0]    opc_n;
  logic          idx_n, ext_n, imm_n, ind_n, err_n;

  assign xoff = fx ? AW'(idx_i) : '0;

  always_comb begin
    len_n = 3'd1; opc_n = instr_i[31:24]; am_n = AM_NONE; rel_n = 2'b00;
    idx_n = 1'b0; ext_n = 1'b0; ta_n = '0; imm_n = 1'b0; ind_n = 1'b0;
    err_n = 1'b0; field = '0;
    case (cls_i)
      2'b01: len_n = 3'd1;
      2'b10: len_n = 3'd2;
      2'b11: err_n = 1'b1;
      default: begin
        opc_n = {instr_i[31:26], 2'b00};
        idx_n = fx;
        if (!fn && !fi) begin
          len_n = 3'd3;
          am_n  = AM_LEGACY;
          ta_n  = AW'({fb, fp, fe, d12}) + xoff;
        end else begin
          len_n = fe ? 3'd4 : 3'd3;
          ext_n = fe;
          rel_n = {fb, fp};
          am_n  = (fn && fi) ? AM_SIMPLE : (fi ? AM_IMM : AM_IND);
          if (fe)      field = AW'(a20);
          else if (fp) field = {{(AW-12){d12[11]}}, d12};
          else         field = AW'(d12);
          case ({fb, fp})
            2'b00: ta_n = field;
            2'b01: ta_n = AW'(pc_i) + field;
            2'b10: ta_n = AW'(base_i) + field;
            default: err_n = 1'b1;
          endcase
          if (fx && !(fn && fi)) err_n = 1'b1;
          if (err_n) ta_n = '0;
          else       ta_n = ta_n + xoff;
          imm_n = !fn && fi && !err_n;
          ind_n = fn && !fi && !err_n;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_o <= '0; opcode_o <= '0; am_o <= '0; rel_o <= '0; idx_o <= 1'b0;
      ext_o <= 1'b0; ta_o <= '0; imm_vld_o <= 1'b0; ind_req_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      len_o <= len_n; opcode_o <= opc_n; am_o <= am_n; rel_o <= rel_n;
      idx_o <= idx_n; ext_o <= ext_n; ta_o <= ta_n; imm_vld_o <= imm_n;
      ind_req_o <= ind_n; err_o <= err_n;
    end
  end

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (ta_o == '0 && !imm_vld_o && !ind_req_o));
  a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_vld_o && ind_req_o));
  a_r2_ext_len: assert property (@(posedge clk) disable iff (!rst_n)
    (am_o != AM_NONE && am_o != AM_LEGACY) |-> (ext_o == (len_o == 3'd4)));
  a_r9_legacy_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (am_o == AM_LEGACY) |-> (len_o == 3'd3 && !ext_o && rel_o == 2'b00));
  a_r1_short_len: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == 2'b10) |=> (len_o == 3'd2 && am_o == AM_NONE && !err_o));
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == 2'b11) |=> err_o);
  a_r11_reset: assert property (@(posedge clk)
    !rst_n |=> (len_o == 3'd0 || rst_n));
endmodule

// File: tb/xe_ta_gen_tb_top.sv
module xe_ta_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [1:0]  cls_i = '0;
  logic [23:0] base_i = '0, idx_i = '0, pc_i = '0;
  logic [2:0]  len_o, am_o;
  logic [7:0]  opcode_o;
  logic [1:0]  rel_o;
  logic        idx_o, ext_o, imm_vld_o, ind_req_o, err_o;
  logic [19:0] ta_o;

  always #5 clk = ~clk;

  xe_ta_gen dut_i (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .cls_i(cls_i),
    .base_i(base_i), .idx_i(idx_i), .pc_i(pc_i), .len_o(len_o),
    .opcode_o(opcode_o), .am_o(am_o), .rel_o(rel_o), .idx_o(idx_o),
    .ext_o(ext_o), .ta_o(ta_o), .imm_vld_o(imm_vld_o),
    .ind_req_o(ind_req_o), .err_o(err_o)
  );

  int checks = 0, errors = 0;
  longint e_len, e_opc, e_am, e_rel, e_idx, e_ext, e_ta, e_imm, e_ind, e_err;
  string  ta_tag;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: what the outputs must show one clock later.
  task automatic model(input logic [31:0] ins, input logic [1:0] c,
                       input logic [23:0] bv, input logic [23:0] xv,
                       input logic [23:0] pv);
    int n, i, x, b, p, e;
    longint d, a, sum, span;
    span = 64'd1 << 20;
    n = ins[25]; i = ins[24]; x = ins[23]; b = ins[22]; p = ins[21]; e = ins[20];
    d = ins[19:8]; a = ins[19:0];
    e_len = 1; e_opc = ins[31:24]; e_am = 0; e_rel = 0; e_idx = 0; e_ext = 0;
    e_ta = 0; e_imm = 0; e_ind = 0; e_err = 0; ta_tag = "R1";
    if (c == 2'b01) e_len = 1;
    else if (c == 2'b10) e_len = 2;
    else if (c == 2'b11) begin e_err = 1; ta_tag = "R10"; end
    else begin
      e_opc = ins[31:24] & 8'hFC;
      e_idx = x;
      if (n == 0 && i == 0) begin
        e_len = 3; e_am = 4; ta_tag = "R9";
        sum = b * 16384 + p * 8192 + e * 4096 + d;
        if (x == 1) sum = sum + (xv % span);
        e_ta = sum % span;
      end else begin
        e_len = (e == 1) ? 4 : 3;
        e_ext = e;
        e_rel = b * 2 + p;
        e_am = (n == 1 && i == 1) ? 1 : ((i == 1) ? 2 : 3);
        if (b == 1 && p == 1) e_err = 1;
        if (x == 1 && !(n == 1 && i == 1)) e_err = 1;
        if (e_err == 1) ta_tag = "R10";
        else begin
          if (e == 1) sum = a;
          else if (p == 1 && d >= 2048) sum = d - 4096;
          else sum = d;
          if (p == 1) begin sum = sum + (pv % span); ta_tag = "R4"; end
          else if (b == 1) begin sum = sum + (bv % span); ta_tag = "R5"; end
          else ta_tag = "R3";
          if (x == 1) begin sum = sum + (xv % span); ta_tag = "R6"; end
          e_ta = ((sum % span) + span) % span;
          e_imm = (n == 0) ? 1 : 0;
          e_ind = (i == 0) ? 1 : 0;
          if (e_imm == 1 && ta_tag == "R3") ta_tag = "R7";
        end
      end
    end
  endtask

  task automatic compare();
    chk("R11_R1_R2 len", len_o, e_len);
    chk("R2 opcode", opcode_o, e_opc);
    chk("R2_R9 am", am_o, e_am);
    chk("R2 rel", rel_o, e_rel);
    chk("R2_R6 idx", idx_o, e_idx);
    chk("R2 ext", ext_o, e_ext);
    chk({ta_tag, " ta"}, ta_o, e_ta);
    chk("R7 imm_vld", imm_vld_o, e_imm);
    chk("R8 ind_req", ind_req_o, e_ind);
    chk("R10 err", err_o, e_err);
  endtask

  task automatic apply(input logic [31:0] ins, input logic [1:0] c,
                       input logic [23:0] bv, input logic [23:0] xv,
                       input logic [23:0] pv);
    @(negedge clk);
    compare();
    instr_i = ins; cls_i = c; base_i = bv; idx_i = xv; pc_i = pv;
    model(ins, c, bv, xv, pv);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [5:0] fl,
                                     input logic [19:0] f);
    return {op, fl, f};
  endfunction

  initial begin
    // R11: reset state
    model(32'h0, 2'b00, 24'h0, 24'h0, 24'h0);
    e_len = 0; e_am = 0; e_ta = 0; e_opc = 0; ta_tag = "R11";
    instr_i = 32'hDEADBEEF; cls_i = 2'b11;
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    model(instr_i, cls_i, base_i, idx_i, pc_i);
    // R1 short formats
    apply(32'hB4_51_0000, 2'b10, 24'h1, 24'h2, 24'h3);
    apply(32'hC7_FF_FFFF, 2'b01, 24'h1, 24'h2, 24'h3);
    // R3 direct, format 3 and 4
    apply(mk(6'h00, 6'b110000, 20'hABC00), 2'b00, 24'h5, 24'h6, 24'h7);
    apply(mk(6'h12, 6'b110001, 20'hFFFFF), 2'b00, 24'h5, 24'h6, 24'h7);
    // R4 PC-relative: negative wrap below zero, positive, format 4 wrap
    apply(mk(6'h0F, 6'b110010, 20'h80000), 2'b00, 24'h0, 24'h0, 24'h000010);
    apply(mk(6'h0F, 6'b110010, 20'h7FF00), 2'b00, 24'h0, 24'h0, 24'hFFFFFF);
    apply(mk(6'h0F, 6'b110011, 20'hFFFFF), 2'b00, 24'h0, 24'h0, 24'h000002);
    // R5 base: max displacement, top-of-space wrap
    apply(mk(6'h15, 6'b110100, 20'hFFF00), 2'b00, 24'h0FFFFF, 24'h0, 24'h0);
    apply(mk(6'h15, 6'b110100, 20'h00000), 2'b00, 24'hABCDE0, 24'h0, 24'h0);
    // R6 indexed with base, wrap
    apply(mk(6'h15, 6'b111100, 20'h00100), 2'b00, 24'h0FFFF0, 24'h0FFFFF, 24'h0);
    // R7 immediate, R8 indirect
    apply(mk(6'h06, 6'b010000, 20'h01E00), 2'b00, 24'h0, 24'h0, 24'h0);
    apply(mk(6'h06, 6'b010001, 20'h12345), 2'b00, 24'h0, 24'h0, 24'h0);
    apply(mk(6'h06, 6'b100010, 20'hFFE00), 2'b00, 24'h0, 24'h0, 24'h100);
    // R9 legacy, with and without index
    apply(mk(6'h00, 6'b000111, 20'hFFF00), 2'b00, 24'h0, 24'h0, 24'h0);
    apply(mk(6'h00, 6'b001111, 20'hFFF00), 2'b00, 24'h0, 24'h0FFFFF, 24'h0);
    // R10 illegal combinations
    apply(mk(6'h0A, 6'b110110, 20'h12300), 2'b00, 24'h1, 24'h1, 24'h1);
    apply(mk(6'h0A, 6'b011000, 20'h12300), 2'b00, 24'h1, 24'h1, 24'h1);
    apply(mk(6'h0A, 6'b101000, 20'h12300), 2'b00, 24'h1, 24'h1, 24'h1);
    apply(32'h12345678, 2'b11, 24'h1, 24'h1, 24'h1);
    // random sweep
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] c;
      c = ($urandom_range(0, 9) < 7) ? 2'b00 : 2'($urandom_range(1, 3));
      apply($urandom, c, 24'($urandom), 24'($urandom), 24'($urandom));
    end
    // R11: reset again clears outputs
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset len", len_o, 0);
    chk("R11 reset ta", ta_o, 0);
    chk("R11 reset err", err_o, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule